// File: doc/BRIEF.md
# Boot Sector Write Protection Controller

This block sits between the command decoder of a 512K-word non-volatile array and its program and erase engines. For every program or erase request it decides whether the request may go ahead, and which physical regions an erase should actually touch. The array is split into four regions: an 8K-word boot region, two 8K-word parameter sectors and a main array. A parameter chooses at elaboration time whether the boot region sits at the bottom or at the top of the address space.

A sticky lock bit models the non-volatile boot-protection fuse. A one-cycle pulse sets it. Once set, word programs aimed at the boot region are refused, and erases leave the boot region alone. While it is clear, the boot region is erased together with the main array, because the two form one erase sector. A high-voltage override flag, sampled with each request, suspends the lock for that request only. The lock bit can be read back as a status word while the identification mode is active.

Each request is presented for one cycle with `req_valid`. The verdict appears on `permit` and `erase_en` in the following cycle and lasts one cycle.

Top module: `bootlock_ctrl`

## Requirements
- R1: After reset the lock bit is clear, `permit` is 0 and `erase_en` is 0.
- R2: Region map, bottom option (TOP_BOOT=0): boot 00000h–01FFFh, parameter 1 02000h–03FFFh, parameter 2 04000h–05FFFh, main above that. Top option (TOP_BOOT=1): boot 7E000h–7FFFFh, parameter 1 7C000h–7DFFFh, parameter 2 7A000h–7BFFFh, main below that.
- R3: `req_kind` 1 is a sector erase. Its target is the region of `req_addr`: a parameter address enables only that parameter bit. A main or boot address enables the main bit, and also the boot bit while unlocked. `erase_en` bit 0 is boot, bit 1 parameter 1, bit 2 parameter 2, bit 3 main.
- R4: With the lock set and no override, a sector erase of the main sector gives `erase_en` = 1000b.
- R5: `req_kind` 2 is a chip erase. It gives 1111b while unlocked and 1110b while locked without override.
- R6: `req_kind` 0 is a word program. It gives `permit`=1 and `erase_en`=0, except that with the lock set and no override a boot-region address gives `permit`=0.
- R7: With `hv_override` high alongside the request, the boot region is programmed or erased even when locked. The next request without the override is again refused.
- R8: A `lock_pulse` sets the lock bit for every later request. No erase, even one with the override, clears it. Only `rst_n` clears it.
- R9: With `id_mode` high and `rd_addr` = 2, `id_data` bit 0 shows the lock bit (1 = locked) and the other bits are 0. In every other case `id_data` is 0.
- R10: The verdict is registered and lasts one cycle. With no request, or with the reserved `req_kind` 3, `permit` and `erase_en` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lock (simulation use) |
| req_valid | input | 1 | Request strobe, one cycle |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | 19 | Word address of the request |
| hv_override | input | 1 | Lock override for this request |
| lock_pulse | input | 1 | One-cycle pulse that sets the lock bit |
| id_mode | input | 1 | Identification mode active |
| rd_addr | input | 19 | Status read address |
| permit | output | 1 | Request allowed (valid the cycle after the request) |
| erase_en | output | 4 | Per-region erase enables {main, par2, par1, boot} |
| locked | output | 1 | Current lock bit |
| id_data | output | 16 | Status read data |

## Verification
The bench goes after the address boundaries of the boot region in both mappings. A decoder that is one sector off would permit a locked program at 01FFFh, or refuse one at 02000h. It checks that the boot enable follows the main-sector erase only while unlocked; a design that ignored the lock would wipe boot code on a plain sector or chip erase. It checks that the override covers one request only, and that an override chip erase leaves the lock set; a design that latched the override, or let an erase clear the fuse, would leave the boot region exposed afterwards. Finally it checks that a boot-region address in a sector erase selects the combined sector, and that the status word shows the lock only at address 2 in identification mode.

// File: rtl/bootlock_pkg.sv
`timescale 1ns/1ps
package bootlock_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_kind_e;

    localparam int RGN_BOOT = 0;
    localparam int RGN_PAR1 = 1;
    localparam int RGN_PAR2 = 2;
    localparam int RGN_MAIN = 3;
    localparam int NUM_RGN  = 4;

    typedef struct packed {
        logic                 permit;
        logic [NUM_RGN-1:0]   erase_en;
    } verdict_t;

endpackage

// File: rtl/bootlock_region_dec.sv
`timescale 1ns/1ps
module bootlock_region_dec
    import bootlock_pkg::*;
#(
    parameter int AW       = 19,
    parameter int SECT_W   = 13,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [AW-1:0]      addr,
    output logic [NUM_RGN-1:0] hit
);
    localparam int IDX_W = AW - SECT_W;
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] idx;
    assign idx = addr[AW-1:SECT_W];

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                hit = '0;
                if (idx == IDX_MAX)               hit[RGN_BOOT] = 1'b1;
                else if (idx == IDX_MAX - 1'b1)   hit[RGN_PAR1] = 1'b1;
                else if (idx == IDX_MAX - 2'd2)   hit[RGN_PAR2] = 1'b1;
                else                              hit[RGN_MAIN] = 1'b1;
            end
        end else begin : g_bottom
            always_comb begin
                hit = '0;
                if (idx == '0)                    hit[RGN_BOOT] = 1'b1;
                else if (idx == IDX_W'(1))        hit[RGN_PAR1] = 1'b1;
                else if (idx == IDX_W'(2))        hit[RGN_PAR2] = 1'b1;
                else                              hit[RGN_MAIN] = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/bootlock_lockbit.sv
`timescale 1ns/1ps
module bootlock_lockbit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    output logic locked
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (set_pulse) lock_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign locked = lock_q;

    // R8: once set, the lock stays set until reset
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8: a pulse always leaves the bit set
    assert_lock_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> lock_q);

endmodule

// File: rtl/bootlock_policy.sv
`timescale 1ns/1ps
module bootlock_policy
    import bootlock_pkg::*;
(
    input  op_kind_e            kind,
    input  logic [NUM_RGN-1:0]  hit,
    input  logic                locked,
    input  logic                hv,
    output verdict_t            verdict
);
    logic boot_open;
    logic combined_sel;

    assign boot_open    = !locked || hv;
    assign combined_sel = hit[RGN_MAIN] || hit[RGN_BOOT];

    always_comb begin
        verdict = '0;
        unique case (kind)
            OP_PROG: begin
                verdict.permit = !hit[RGN_BOOT] || boot_open;
            end
            OP_SECT: begin
                verdict.permit             = 1'b1;
                verdict.erase_en[RGN_PAR1] = hit[RGN_PAR1];
                verdict.erase_en[RGN_PAR2] = hit[RGN_PAR2];
                verdict.erase_en[RGN_MAIN] = combined_sel;
                verdict.erase_en[RGN_BOOT] = combined_sel && boot_open;
            end
            OP_CHIP: begin
                verdict.permit             = 1'b1;
                verdict.erase_en[RGN_PAR1] = 1'b1;
                verdict.erase_en[RGN_PAR2] = 1'b1;
                verdict.erase_en[RGN_MAIN] = 1'b1;
                verdict.erase_en[RGN_BOOT] = boot_open;
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/bootlock_ctrl.sv
`timescale 1ns/1ps
module bootlock_ctrl
    import bootlock_pkg::*;
#(
    parameter int AW       = 19,
    parameter int DW       = 16,
    parameter int SECT_W   = 13,
    parameter bit TOP_BOOT = 1'b0,
    parameter int ID_ADDR  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [AW-1:0]       req_addr,
    input  logic                hv_override,
    input  logic                lock_pulse,
    input  logic                id_mode,
    input  logic [AW-1:0]       rd_addr,
    output logic                permit,
    output logic [NUM_RGN-1:0]  erase_en,
    output logic                locked,
    output logic [DW-1:0]       id_data
);
    op_kind_e            kind;
    logic [NUM_RGN-1:0]  hit;
    logic                lock_now;
    verdict_t            verdict;
    verdict_t            out_d, out_q;

    assign kind = op_kind_e'(req_kind);

    bootlock_region_dec #(
        .AW       (AW),
        .SECT_W   (SECT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_dec (
        .addr (req_addr),
        .hit  (hit)
    );

    bootlock_lockbit u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (lock_pulse),
        .locked    (lock_now)
    );

    bootlock_policy u_pol (
        .kind    (kind),
        .hit     (hit),
        .locked  (lock_now),
        .hv      (hv_override),
        .verdict (verdict)
    );

    always_comb begin
        out_d = '0;
        if (req_valid) out_d = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign permit   = out_q.permit;
    assign erase_en = out_q.erase_en;
    assign locked   = lock_now;

    always_comb begin
        id_data = '0;
        if (id_mode && rd_addr == AW'(ID_ADDR)) id_data[0] = lock_now;
    end

    // R6: locked boot program without override is refused
    assert_boot_prog_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == OP_PROG && hit[RGN_BOOT] && lock_now && !hv_override)
        |=> !permit);

    // R4: locked erase without override never touches the boot region
    assert_boot_erase_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind != OP_PROG && lock_now && !hv_override)
        |=> !erase_en[RGN_BOOT]);

    // R5: chip erase always covers main and both parameter sectors
    assert_chip_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == OP_CHIP)
        |=> (erase_en[RGN_MAIN] && erase_en[RGN_PAR1] && erase_en[RGN_PAR2]));

    // R10: no request gives a quiet verdict
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!permit && erase_en == '0));

    // R6: a program never raises an erase enable
    assert_prog_no_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == OP_PROG) |=> (erase_en == '0));

endmodule

// File: tb/tb_bootlock_ctrl.sv
`timescale 1ns/1ps
module tb_bootlock_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [18:0] req_addr = '0;
    logic        hv_override = 1'b0;
    logic        lock_pulse = 1'b0;
    logic        id_mode = 1'b0;
    logic [18:0] rd_addr = '0;

    logic        permit_b, locked_b, permit_t, locked_t;
    logic [3:0]  en_b, en_t;
    logic [15:0] id_b, id_t;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bootlock_ctrl #(.TOP_BOOT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .hv_override(hv_override), .lock_pulse(lock_pulse),
        .id_mode(id_mode), .rd_addr(rd_addr),
        .permit(permit_b), .erase_en(en_b), .locked(locked_b), .id_data(id_b));

    bootlock_ctrl #(.TOP_BOOT(1'b1)) dut_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .hv_override(hv_override), .lock_pulse(lock_pulse),
        .id_mode(id_mode), .rd_addr(rd_addr),
        .permit(permit_t), .erase_en(en_t), .locked(locked_t), .id_data(id_t));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [18:0] a, input logic hv);
        req_valid = 1'b1; req_kind = k; req_addr = a; hv_override = hv;
        @(negedge clk);
        req_valid = 1'b0; hv_override = 1'b0;
    endtask

    task automatic pulse_lock();
        lock_pulse = 1'b1;
        @(negedge clk);
        lock_pulse = 1'b0;
    endtask

    // {setlock, kind[1:0], addr[18:0], hv, exp_permit, exp_en[3:0]} for bottom mapping
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 2'd0, 19'h00010, 1'b0, 1'b1, 4'b0000},  // R6 unlocked boot program
        {1'b0, 2'd0, 19'h06000, 1'b0, 1'b1, 4'b0000},  // R6 main program
        {1'b0, 2'd1, 19'h03000, 1'b0, 1'b1, 4'b0010},  // R3 param 1
        {1'b0, 2'd1, 19'h05000, 1'b0, 1'b1, 4'b0100},  // R3 param 2
        {1'b0, 2'd1, 19'h7F000, 1'b0, 1'b1, 4'b1001},  // R3 main + boot unlocked
        {1'b0, 2'd2, 19'h05555, 1'b0, 1'b1, 4'b1111},  // R5 unlocked chip
        {1'b0, 2'd3, 19'h00000, 1'b0, 1'b0, 4'b0000},  // R10 reserved kind
        {1'b1, 2'd0, 19'h00010, 1'b0, 1'b0, 4'b0000},  // R6 locked boot program
        {1'b0, 2'd0, 19'h01FFF, 1'b0, 1'b0, 4'b0000},  // R2 last boot word
        {1'b0, 2'd0, 19'h02000, 1'b0, 1'b1, 4'b0000},  // R2 first param word
        {1'b0, 2'd1, 19'h7F000, 1'b0, 1'b1, 4'b1000},  // R4 locked main sector
        {1'b0, 2'd2, 19'h05555, 1'b0, 1'b1, 4'b1110},  // R5 locked chip
        {1'b0, 2'd0, 19'h01000, 1'b1, 1'b1, 4'b0000},  // R7 override program
        {1'b0, 2'd0, 19'h01000, 1'b0, 1'b0, 4'b0000},  // R7 override released
        {1'b0, 2'd1, 19'h7F000, 1'b1, 1'b1, 4'b1001},  // R7 override sector
        {1'b0, 2'd2, 19'h05555, 1'b1, 1'b1, 4'b1111},  // R7 override chip
        {1'b0, 2'd1, 19'h00100, 1'b0, 1'b1, 4'b1000}   // R3 boot addr -> combined
    };

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 permit", {15'd0, permit_b}, 16'd0);
        check("R1 erase_en", {12'd0, en_b}, 16'd0);
        check("R1 locked", {15'd0, locked_b}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 locked after release", {15'd0, locked_b}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) pulse_lock();
            issue(VEC[i][26:25], VEC[i][24:6], VEC[i][5]);
            check($sformatf("vec%0d permit", i), {15'd0, permit_b}, {15'd0, VEC[i][4]});
            check($sformatf("vec%0d erase_en", i), {12'd0, en_b}, {12'd0, VEC[i][3:0]});
        end

        // R10 one-cycle verdict, idle afterwards
        @(negedge clk);
        check("R10 idle permit", {15'd0, permit_b}, 16'd0);
        check("R10 idle erase_en", {12'd0, en_b}, 16'd0);

        // R8 lock survives override chip erase
        check("R8 lock sticky", {15'd0, locked_b}, 16'd1);

        // R9 status read
        id_mode = 1'b1; rd_addr = 19'd2; #1;
        check("R9 id lock", id_b, 16'h0001);
        rd_addr = 19'd3; #1;
        check("R9 other addr", id_b, 16'h0000);
        id_mode = 1'b0; rd_addr = 19'd2; #1;
        check("R9 no id mode", id_b, 16'h0000);

        // R2 top mapping, locked
        issue(2'd0, 19'h7E000, 1'b0);
        check("R2 top boot prog locked", {15'd0, permit_t}, 16'd0);
        issue(2'd0, 19'h7DFFF, 1'b0);
        check("R2 top par1 prog", {15'd0, permit_t}, 16'd1);
        issue(2'd1, 19'h7D000, 1'b0);
        check("R3 top par1 erase", {12'd0, en_t}, 16'h0002);
        issue(2'd1, 19'h7B000, 1'b0);
        check("R3 top par2 erase", {12'd0, en_t}, 16'h0004);
        issue(2'd1, 19'h79000, 1'b0);
        check("R4 top main locked", {12'd0, en_t}, 16'h0008);
        issue(2'd0, 19'h7FFFF, 1'b1);
        check("R7 top override prog", {15'd0, permit_t}, 16'd1);

        // R8 reset clears the lock
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset clears lock", {15'd0, locked_t}, 16'd0);
        id_mode = 1'b1; rd_addr = 19'd2; #1;
        check("R9 id unlocked", id_b, 16'h0000);
        id_mode = 1'b0;
        issue(2'd1, 19'h79000, 1'b0);
        check("R3 top main unlocked", {12'd0, en_t}, 16'h0009);
        issue(2'd0, 19'h7E000, 1'b0);
        check("R6 top boot prog unlocked", {15'd0, permit_t}, 16'd1);
        issue(2'd2, 19'h05555, 1'b0);
        check("R5 top chip unlocked", {12'd0, en_t}, 16'h000F);

        // R8 pulse coincident with a request: effective from the next one
        lock_pulse = 1'b1;
        issue(2'd0, 19'h00010, 1'b0);
        lock_pulse = 1'b0;
        check("R8 same-cycle pulse uses old lock", {15'd0, permit_b}, 16'd1);
        issue(2'd0, 19'h00010, 1'b0);
        check("R8 lock active next request", {15'd0, permit_b}, 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule